// File: doc/BRIEF.md
# Multi-Mode Reload and Capture Timer

This block is a down-counting timer with two shared value registers, A and B, and three operating modes picked by a 3-bit mode field. In waveform mode the counter is decremented every clock. Each underflow reloads it and can invert an output pin. The first underflow after entry reloads from A. Later underflows alternate B, A, B, and so on, so A and B set the high and low times. In event mode the counter is decremented only by edges on input pin A, and a rising edge on input pin B serves as a separate interrupt source. In capture mode the counter runs freely and wraps. A rising edge on pin A copies the count into A, and a rising edge on pin B copies it into B.

A host writes and reads four word locations: the two value registers, a control word, and a status word. The status word holds two sticky pending flags, and writing a 1 to a flag clears it. The interrupt output is high while either flag is set and its enable bit in the control word is set.

The sequencer has six named states. IDLE: no counting. PWM_FIRST: next reload from A. PWM_NEXT_B: next reload from B. PWM_NEXT_A: next reload from A. EVENT: counting pin edges. CAPTURE: free-running. The transitions are these:
- enter_mode: a control write that changes the mode field moves to the entry state of the new mode.
- reload_a: PWM_FIRST or PWM_NEXT_A moves to PWM_NEXT_B on an underflow.
- reload_b: PWM_NEXT_B moves to PWM_NEXT_A on an underflow.

Every other condition holds the state.

Top module: `reload_capture_timer`

## Requirements
- R1: The control word bits [2:0] select the mode: 001 waveform, 010 event on rising pin-A edges, 011 event on falling pin-A edges, 100 capture. Any other value is idle. In idle the counter holds, no flag is set by pin activity, and the output pin stays low.
- R2: In waveform mode the counter is decremented every clock. A clock with the count at zero is an underflow and loads a reload value instead. The first underflow after entering the mode loads A, and later ones load B, A, B, and so on.
- R3: When toggle enable (control bit 3) is 1, every waveform underflow inverts the output pin. The pin is then high for A+1 clocks and low for B+1 clocks. With the bit at 0 the pin stays low.
- R4: A waveform underflow that loads A sets flag A (status bit 0). One that loads B sets flag B (status bit 1).
- R5: Writing the status word clears each flag whose data bit is 1. If a flag is set in the same clock as its clear, it ends up set.
- R6: The interrupt output is (flag A and control bit 4) or (flag B and control bit 5).
- R7: In event mode each selected pin-A edge decrements the counter. An edge with the count at zero reloads from A and sets flag A. The output pin stays low.
- R8: In event mode a rising edge on pin B sets flag B.
- R9: In capture mode the counter is decremented every clock and wraps. A rising pin-A edge stores the current count in A and sets flag A. A rising pin-B edge stores the count in B and sets flag B. A capture takes priority over a host write to the same register.
- R10: Each input pin passes through two synchronizing flops. A pin edge first acts on the third rising clock edge after it.
- R11: A control write that changes the mode field clears the counter and the output pin, and makes the next waveform reload come from A. A write that keeps the mode field restarts nothing.
- R12: The read address selects the word: 0 reads A, 1 reads B, 2 reads the 6-bit control word (upper bits zero), 3 reads the flags in bits [1:0]. All registers are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for one clock |
| wr_addr | input | 2 | Word written |
| wr_data | input | WIDTH | Write data |
| rd_addr | input | 2 | Word read |
| rd_data | output | WIDTH | Read data, combinational from rd_addr |
| pin_a_in | input | 1 | Asynchronous input pin A |
| pin_b_in | input | 1 | Asynchronous input pin B |
| pin_a_out | output | 1 | Waveform output |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong alternation state appears at the output pin within one period, as swapped high and low widths. It also appears as the wrong flag in the status word on the first underflow. A counter that is off by one shows up as a pulse one clock too long or too short, and capture values that are off by the same amount. A synchronizer with the wrong depth moves flag setting by a whole clock against a pin edge. That is visible by reading the status word on the second and third clocks after the edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int CTRL_BITS  = 6;
    localparam int MODE_MSB   = 2;
    localparam int TOG_BIT    = 3;
    localparam int EN_A_BIT   = 4;
    localparam int EN_B_BIT   = 5;
    localparam int FLAG_A_BIT = 0;
    localparam int FLAG_B_BIT = 1;

    localparam logic [1:0] ADDR_VAL_A  = 2'd0;
    localparam logic [1:0] ADDR_VAL_B  = 2'd1;
    localparam logic [1:0] ADDR_CTRL   = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam logic [2:0] MODE_IDLE     = 3'b000;
    localparam logic [2:0] MODE_PWM      = 3'b001;
    localparam logic [2:0] MODE_EVT_RISE = 3'b010;
    localparam logic [2:0] MODE_EVT_FALL = 3'b011;
    localparam logic [2:0] MODE_CAPTURE  = 3'b100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PWM_FIRST,
        ST_PWM_NEXT_B,
        ST_PWM_NEXT_A,
        ST_EVENT,
        ST_CAPTURE
    } seq_state_e;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sync_q,
    output logic hist_q
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] chain_q;

    generate
        if (STAGES > 1) begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[TOP-1:0], din};
            end
        end else begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= din;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= 1'b0;
        else        hist_q <= chain_q[TOP];
    end

    assign sync_q = chain_q[TOP];

endmodule

// File: rtl/tmr_sequencer.sv
module tmr_sequencer
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       mode,
    input  logic             mode_load,
    input  logic [2:0]       new_mode,
    input  logic             tog_en,
    input  logic [WIDTH-1:0] val_a,
    input  logic [WIDTH-1:0] val_b,
    input  logic             a_sync,
    input  logic             a_hist,
    input  logic             b_sync,
    input  logic             b_hist,
    output logic             set_a,
    output logic             set_b,
    output logic             cap_a,
    output logic             cap_b,
    output logic [WIDTH-1:0] count,
    output logic             pin_out
);
    seq_state_e state_q, state_d;
    logic [WIDTH-1:0] cnt_q, reload_val;
    logic tick, at_zero, underflow, pwm_state;
    logic a_rise, a_fall, b_rise;

    assign a_rise    = a_sync & ~a_hist;
    assign a_fall    = ~a_sync & a_hist;
    assign b_rise    = b_sync & ~b_hist;
    assign at_zero   = (cnt_q == '0);
    assign pwm_state = (state_q == ST_PWM_FIRST) || (state_q == ST_PWM_NEXT_A)
                    || (state_q == ST_PWM_NEXT_B);

    function automatic seq_state_e entry_state(input logic [2:0] m);
        case (m)
            MODE_PWM:                     return ST_PWM_FIRST;
            MODE_EVT_RISE, MODE_EVT_FALL: return ST_EVENT;
            MODE_CAPTURE:                 return ST_CAPTURE;
            default:                      return ST_IDLE;
        endcase
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (mode_load) begin
            state_d = entry_state(new_mode);
        end else begin
            unique case (state_q)
                ST_PWM_FIRST,
                ST_PWM_NEXT_A: if (at_zero) state_d = ST_PWM_NEXT_B;
                ST_PWM_NEXT_B: if (at_zero) state_d = ST_PWM_NEXT_A;
                ST_IDLE, ST_EVENT, ST_CAPTURE: state_d = state_q;
                default:       state_d = ST_IDLE;
            endcase
        end
    end

    // per-state outputs
    always_comb begin
        tick       = 1'b0;
        reload_val = val_a;
        set_a      = 1'b0;
        set_b      = 1'b0;
        cap_a      = 1'b0;
        cap_b      = 1'b0;
        if (!mode_load) begin
            unique case (state_q)
                ST_PWM_FIRST, ST_PWM_NEXT_A: begin
                    tick  = 1'b1;
                    set_a = at_zero;
                end
                ST_PWM_NEXT_B: begin
                    tick       = 1'b1;
                    reload_val = val_b;
                    set_b      = at_zero;
                end
                ST_EVENT: begin
                    tick  = (mode == MODE_EVT_FALL) ? a_fall : a_rise;
                    set_a = tick & at_zero;
                    set_b = b_rise;
                end
                ST_CAPTURE: begin
                    tick  = 1'b1;
                    cap_a = a_rise;
                    cap_b = b_rise;
                    set_a = a_rise;
                    set_b = b_rise;
                end
                default: tick = 1'b0;
            endcase
        end
    end

    assign underflow = tick && at_zero && (state_q != ST_CAPTURE);

    // counter and output pin
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            pin_out <= 1'b0;
        end else if (mode_load) begin
            cnt_q   <= '0;
            pin_out <= 1'b0;
        end else begin
            if (underflow)  cnt_q <= reload_val;
            else if (tick)  cnt_q <= cnt_q - 1'b1;
            if (underflow && pwm_state && tog_en) pin_out <= ~pin_out;
        end
    end

    assign count = cnt_q;

    assert_first_from_a_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PWM_FIRST) |-> !set_b);

    assert_reload_value_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_state && at_zero && !mode_load)
        |=> (cnt_q == $past((state_q == ST_PWM_NEXT_B) ? val_b : val_a)));

    assert_one_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        pwm_state |-> $onehot0({set_a, set_b}));

    assert_out_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EVENT || state_q == ST_CAPTURE || state_q == ST_IDLE) |-> !pin_out);

    assert_edge_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        a_rise |=> !a_rise);

    assert_restart_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mode_load |=> (cnt_q == '0 && !pin_out));

endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    input  logic             set_a,
    input  logic             set_b,
    input  logic             cap_a,
    input  logic             cap_b,
    input  logic [WIDTH-1:0] count,
    output logic [WIDTH-1:0] val_a,
    output logic [WIDTH-1:0] val_b,
    output logic [2:0]       mode,
    output logic             tog_en,
    output logic             mode_load,
    output logic [2:0]       new_mode,
    output logic [WIDTH-1:0] rd_data,
    output logic             irq
);
    logic [CTRL_BITS-1:0] ctrl_q;
    logic pend_a_q, pend_b_q;
    logic wr_a, wr_b, wr_ctl, wr_st, clr_a, clr_b, en_a, en_b;

    assign wr_a   = wr_en && (wr_addr == ADDR_VAL_A);
    assign wr_b   = wr_en && (wr_addr == ADDR_VAL_B);
    assign wr_ctl = wr_en && (wr_addr == ADDR_CTRL);
    assign wr_st  = wr_en && (wr_addr == ADDR_STATUS);
    assign clr_a  = wr_st && wr_data[FLAG_A_BIT];
    assign clr_b  = wr_st && wr_data[FLAG_B_BIT];

    assign mode      = ctrl_q[MODE_MSB:0];
    assign tog_en    = ctrl_q[TOG_BIT];
    assign en_a      = ctrl_q[EN_A_BIT];
    assign en_b      = ctrl_q[EN_B_BIT];
    assign new_mode  = wr_data[MODE_MSB:0];
    assign mode_load = wr_ctl && (new_mode != mode);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_a    <= '0;
            val_b    <= '0;
            ctrl_q   <= '0;
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else begin
            if (cap_a)     val_a <= count;
            else if (wr_a) val_a <= wr_data;
            if (cap_b)     val_b <= count;
            else if (wr_b) val_b <= wr_data;
            if (wr_ctl)    ctrl_q <= wr_data[CTRL_BITS-1:0];
            pend_a_q <= (pend_a_q & ~clr_a) | set_a;
            pend_b_q <= (pend_b_q & ~clr_b) | set_b;
        end
    end

    assign irq = (pend_a_q & en_a) | (pend_b_q & en_b);

    always_comb begin
        unique case (rd_addr)
            ADDR_VAL_A:  rd_data = val_a;
            ADDR_VAL_B:  rd_data = val_b;
            ADDR_CTRL:   rd_data = {{(WIDTH-CTRL_BITS){1'b0}}, ctrl_q};
            ADDR_STATUS: rd_data = {{(WIDTH-2){1'b0}}, pend_b_q, pend_a_q};
            default:     rd_data = '0;
        endcase
    end

    assert_flag_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_a_q && !clr_a) |=> pend_a_q);

    assert_set_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_b |=> pend_b_q);

    assert_irq_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (set_a && en_a && !wr_ctl) |=> irq);

    assert_capture_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cap_a |=> (val_a == $past(count)));

endmodule

// File: rtl/reload_capture_timer.sv
module reload_capture_timer
    import tmr_pkg::*;
#(
    parameter int WIDTH       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [1:0]       rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             pin_a_in,
    input  logic             pin_b_in,
    output logic             pin_a_out,
    output logic             irq
);
    logic a_sync, a_hist, b_sync, b_hist;
    logic set_a, set_b, cap_a, cap_b, tog_en, mode_load;
    logic [2:0] mode, new_mode;
    logic [WIDTH-1:0] val_a, val_b, count;

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_a (
        .clk(clk), .rst_n(rst_n), .din(pin_a_in), .sync_q(a_sync), .hist_q(a_hist));

    tmr_sync #(.STAGES(SYNC_STAGES)) u_sync_b (
        .clk(clk), .rst_n(rst_n), .din(pin_b_in), .sync_q(b_sync), .hist_q(b_hist));

    tmr_sequencer #(.WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .mode(mode), .mode_load(mode_load),
        .new_mode(new_mode), .tog_en(tog_en), .val_a(val_a), .val_b(val_b),
        .a_sync(a_sync), .a_hist(a_hist), .b_sync(b_sync), .b_hist(b_hist),
        .set_a(set_a), .set_b(set_b), .cap_a(cap_a), .cap_b(cap_b),
        .count(count), .pin_out(pin_a_out));

    tmr_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .set_a(set_a), .set_b(set_b),
        .cap_a(cap_a), .cap_b(cap_b), .count(count), .val_a(val_a),
        .val_b(val_b), .mode(mode), .tog_en(tog_en), .mode_load(mode_load),
        .new_mode(new_mode), .rd_data(rd_data), .irq(irq));

endmodule

// File: tb/reload_capture_timer_tb_top.sv
module reload_capture_timer_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic        pin_a = 1'b0;
    logic        pin_b = 1'b0;
    logic [15:0] rd_data;
    logic        pin_a_out;
    logic        irq;

    int errors = 0;
    int checks = 0;
    string cur_req = "R12";

    always #10 clk = ~clk;

    reload_capture_timer #(.WIDTH(16), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .pin_a_in(pin_a), .pin_b_in(pin_b), .pin_a_out(pin_a_out), .irq(irq));

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference
    int m_a, m_b, m_cnt;
    bit m_nextb, m_out, m_fa, m_fb;
    int m_ctrl;
    bit s1a, s2a, pa, s1b, s2b, pb;

    function automatic int m_read(input int a);
        case (a)
            0: return m_a;
            1: return m_b;
            2: return m_ctrl;
            default: return (int'(m_fb) << 1) | int'(m_fa);
        endcase
    endfunction

    task automatic m_step();
        int mode, old_a, old_b, old_cnt;
        bit ea_r, ea_f, eb_r, mode_wr, set_a, set_b, cap_a, cap_b, tick;
        mode = m_ctrl & 7;
        old_a = m_a; old_b = m_b; old_cnt = m_cnt;
        ea_r = s2a & !pa; ea_f = !s2a & pa; eb_r = s2b & !pb;
        mode_wr = wr_en && wr_addr == 2 && int'(wr_data[2:0]) != mode;
        set_a = 0; set_b = 0; cap_a = 0; cap_b = 0;
        if (mode_wr) begin
            m_cnt = 0; m_nextb = 0; m_out = 0;
        end else if (mode == 1) begin
            if (m_cnt == 0) begin
                if (m_nextb) begin m_cnt = old_b; set_b = 1; end
                else begin m_cnt = old_a; set_a = 1; end
                m_nextb = !m_nextb;
                if (m_ctrl & 8) m_out = !m_out;
            end else m_cnt = m_cnt - 1;
        end else if (mode == 2 || mode == 3) begin
            tick = (mode == 2) ? ea_r : ea_f;
            if (tick) begin
                if (m_cnt == 0) begin m_cnt = old_a; set_a = 1; end
                else m_cnt = m_cnt - 1;
            end
            set_b = eb_r;
        end else if (mode == 4) begin
            cap_a = ea_r; cap_b = eb_r; set_a = ea_r; set_b = eb_r;
            m_cnt = (m_cnt - 1) & 16'hFFFF;
        end
        if (cap_a) m_a = old_cnt; else if (wr_en && wr_addr == 0) m_a = wr_data;
        if (cap_b) m_b = old_cnt; else if (wr_en && wr_addr == 1) m_b = wr_data;
        if (wr_en && wr_addr == 2) m_ctrl = wr_data[5:0];
        if (wr_en && wr_addr == 3) begin
            if (wr_data[0]) m_fa = 0;
            if (wr_data[1]) m_fb = 0;
        end
        m_fa = m_fa | set_a;
        m_fb = m_fb | set_b;
        pa = s2a; s2a = s1a; s1a = pin_a;
        pb = s2b; s2b = s1b; s1b = pin_b;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_a = 0; m_b = 0; m_cnt = 0; m_ctrl = 0;
            m_nextb = 0; m_out = 0; m_fa = 0; m_fb = 0;
            s1a = 0; s2a = 0; pa = 0; s1b = 0; s2b = 0; pb = 0;
        end else begin
            m_step();
        end
        #1;
        if (rst_n) begin
            chk(cur_req, "model pin_a_out", int'(pin_a_out), int'(m_out));
            chk(cur_req, "model irq", int'(irq),
                int'((m_fa && (m_ctrl & 16) != 0) || (m_fb && (m_ctrl & 32) != 0)));
            chk(cur_req, "model rd_data", int'(rd_data), m_read(int'(rd_addr)));
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1; wr_addr = a[1:0]; wr_data = d[15:0];
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        rd_addr = a[1:0];
        #1;
        d = int'(rd_data);
    endtask

    task automatic pulse_a();
        @(negedge clk); pin_a = 1;
        repeat (3) @(negedge clk);
        pin_a = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic pulse_b();
        @(negedge clk); pin_b = 1;
        repeat (3) @(negedge clk);
        pin_b = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int v, n, ra, rb;
        repeat (4) @(negedge clk);
        rst_n = 1;

        // R12 reset state and register map
        cur_req = "R12";
        for (int i = 0; i < 4; i++) begin
            rd(i, v);
            chk("R12", "reset read", v, 0);
        end
        chk("R12", "reset pin_a_out", int'(pin_a_out), 0);
        chk("R12", "reset irq", int'(irq), 0);
        wr(0, 16'h1234);
        rd(0, v);
        chk("R12", "value A readback", v, 16'h1234);

        // R2 R3 R4 waveform with A=3, B=5
        cur_req = "R3";
        wr(0, 3); wr(1, 5);
        wr(2, 16'h19);
        n = 0;
        while (!pin_a_out && n < 50) begin @(posedge clk); #1; n++; end
        n = 0;
        while (pin_a_out && n < 50) begin n++; @(posedge clk); #1; end
        chk("R3", "high time A+1", n, 4);
        n = 0;
        while (!pin_a_out && n < 50) begin n++; @(posedge clk); #1; end
        chk("R3", "low time B+1", n, 6);
        cur_req = "R4";
        rd(3, v);
        chk("R4", "both flags after A and B reloads", v, 3);

        // R6 R5 interrupt and clearing
        cur_req = "R6";
        wr(2, 16'h10);
        chk("R6", "irq with flag A enabled", int'(irq), 1);
        wr(3, 1);
        rd(3, v);
        chk("R5", "clear A only", v, 2);
        chk("R6", "irq with only disabled flag B", int'(irq), 0);
        wr(2, 16'h20);
        chk("R6", "irq with flag B enabled", int'(irq), 1);
        wr(3, 2);
        rd(3, v);
        chk("R5", "clear B", v, 0);

        // R3 toggle disabled, R11 same-mode write keeps running
        cur_req = "R3";
        wr(2, 16'h01);
        repeat (20) @(negedge clk);
        chk("R3", "no toggle when disabled", int'(pin_a_out), 0);
        cur_req = "R11";
        wr(2, 16'h09);
        wr(2, 16'h39);
        repeat (30) @(negedge clk);
        wr(2, 16'h09);
        repeat (10) @(negedge clk);

        // R1 idle and undefined modes
        cur_req = "R1";
        wr(2, 0);
        wr(3, 3);
        pulse_a(); pulse_b();
        rd(3, v);
        chk("R1", "idle ignores pins", v, 0);
        wr(2, 5);
        pulse_a(); pulse_b();
        rd(3, v);
        chk("R1", "undefined mode ignores pins", v, 0);
        chk("R1", "undefined mode output low", int'(pin_a_out), 0);

        // R7 event counting on rising edges, A=2
        cur_req = "R7";
        wr(0, 2);
        wr(2, 16'h02);
        pulse_a();
        rd(3, v);
        chk("R7", "first edge underflows from zero", v, 1);
        wr(3, 3);
        pulse_a(); pulse_a();
        rd(3, v);
        chk("R7", "no underflow before count reaches zero", v, 0);
        pulse_a();
        rd(3, v);
        chk("R7", "underflow after A+1 edges", v, 1);
        chk("R7", "output low in event mode", int'(pin_a_out), 0);

        // R8 pin B interrupt source
        cur_req = "R8";
        wr(3, 3);
        pulse_b();
        rd(3, v);
        chk("R8", "pin B edge sets flag B only", v, 2);

        // R5 set wins over clear in the same clock
        cur_req = "R5";
        wr(3, 3);
        @(negedge clk); pin_b = 1;
        @(negedge clk);
        wr(3, 3);
        rd(3, v);
        chk("R5", "flag B set in clear cycle survives", v, 2);
        pin_b = 0;
        repeat (4) @(negedge clk);

        // R7 falling-edge selection
        cur_req = "R7";
        wr(0, 0);
        wr(2, 16'h03);
        wr(3, 3);
        @(negedge clk); pin_a = 1;
        repeat (5) @(negedge clk);
        rd(3, v);
        chk("R7", "rising edge ignored in falling mode", v, 0);
        pin_a = 0;
        repeat (4) @(negedge clk);
        rd(3, v);
        chk("R7", "falling edge underflows", v, 1);

        // R10 latency and R9 capture
        cur_req = "R10";
        wr(2, 16'h04);
        wr(3, 3);
        rd_addr = 3;
        @(negedge clk); pin_a = 1;
        @(posedge clk); #1;
        chk("R10", "flag clear after 1st edge", int'(rd_data), 0);
        @(posedge clk); #1;
        chk("R10", "flag clear after 2nd edge", int'(rd_data), 0);
        @(posedge clk); #1;
        chk("R10", "flag set after 3rd edge", int'(rd_data), 1);
        @(negedge clk); pin_a = 0;
        repeat (4) @(negedge clk);
        cur_req = "R9";
        wr(3, 3);
        @(negedge clk); pin_a = 1;
        repeat (7) @(negedge clk);
        pin_b = 1;
        repeat (5) @(negedge clk);
        rd(0, ra); rd(1, rb);
        chk("R9", "capture spacing A minus B", (ra - rb) & 16'hFFFF, 7);
        rd(3, v);
        chk("R9", "capture flags", v, 3);
        pin_a = 0; pin_b = 0;
        repeat (4) @(negedge clk);
        @(negedge clk); pin_a = 1;
        repeat (2) @(negedge clk);
        wr(0, 16'h5555);
        repeat (4) @(negedge clk);
        pin_a = 0;
        repeat (4) @(negedge clk);

        // R11 mode change restarts waveform from A
        cur_req = "R11";
        wr(0, 1); wr(1, 4);
        wr(2, 16'h09);
        repeat (7) @(negedge clk);
        wr(2, 16'h00);
        chk("R11", "mode change clears output", int'(pin_a_out), 0);
        wr(2, 16'h09);
        n = 0;
        while (!pin_a_out && n < 50) begin @(posedge clk); #1; n++; end
        n = 0;
        while (pin_a_out && n < 50) begin n++; @(posedge clk); #1; end
        chk("R2", "restart reloads A first", n, 2);
        repeat (20) @(negedge clk);

        summary();
        $finish;
    end

endmodule